// File: doc/BRIEF.md
# Indexed Performance Counter Bank

A bank of event counters that software programs through a narrow window of registers. An index register chooses one counter, and the per-counter registers then act on that counter alone. Through these registers software chooses which event condition the counter follows and loads its count. It can also take a coherent snapshot of the count and set a threshold that raises an interrupt. A single global run bit gates all counting. Condition number zero never fires, so software stops a counter by giving it that condition.

Each counter is `32 + 16*CNT_S` bits wide, so wide values go over the 32-bit bus in low and high words. A snapshot copies the whole counter into a holding pair in one edge, so software can read the two halves without a carry slipping in between. When a counted event brings a counter exactly to its threshold and that counter's interrupt enable is set, its active flag goes up. The interrupt line is the OR of the active flags. Software clears flags by writing ones, and the same write also drops the matching enables, which software then sets again.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset every register reads zero except the build word at 0xB, and `irq` is low.
- R2: Offset 0x0 holds a 5-bit counter index. The registers at offsets 0x2, 0x3, 0x4, 0x7 and 0x8 act only on the counter it names. An index of NUM_CTR or above reads zero there and ignores writes.
- R3: Each counter is CW = 32+16*CNT_S bits. Offset 0x3 reads or writes bits [31:0] and offset 0x4 bits [CW-1:32], zero-extended on read, with write bits above CW ignored. The count wraps modulo 2^CW.
- R4: Bit 0 of offset 0x1 is the global run bit, and while it is 0 no counter changes except by a write. Bits [31:2] of 0x1 read zero and ignore writes.
- R5: Offset 0x2 holds a condition number of clog2(NUM_COND) bits. A counter adds one on each clock where run is 1, its condition c is nonzero and `cond_pulse[c]` is high. Condition 0 never counts.
- R6: Writing offset 0x1 with bit 1 set copies the selected counter, as it stood before that edge, into a snapshot read at 0x5 (low) and 0x6 (high). The snapshot holds otherwise, and bit 1 reads zero.
- R7: Offsets 0x7/0x8 are the selected counter's threshold (low/high). When a counted event makes a count equal to its threshold and bit i of the enable register at 0x9 is set, bit i of the active register at 0xA sets at that edge.
- R8: Writing a 1 to bit i of 0xA clears active bit i and enable bit i, and writing all ones clears every flag. A threshold hit in the same cycle still sets its flag.
- R9: `irq` is high exactly while some active bit is set, and stays high until all are cleared.
- R10: A count write to the selected counter in the same cycle as one of its events takes the written value, drops the event and raises no threshold hit.
- R11: Offset 0xB reads NUM_CTR in [5:0], CNT_S in [9:8], 1 in [12] and NUM_COND in [23:16]. All other bits read zero.
- R12: Offsets 0xC to 0xF read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cond_pulse | input | NUM_COND | One level per event condition, sampled each clock |
| irq | output | 1 | OR of all interrupt active flags |

## Verification
The assertions assume that `bus_addr`, `bus_wdata` and `bus_wr` are stable around each rising edge and that `cond_pulse` carries no unknown values. The bench drives all inputs on the falling edge only. The checks on snapshot hold, on counts holding while run is off, and on condition zero leave out any cycle that writes the count or requests a snapshot. The flag checks allow a threshold hit to land in the same cycle as a clearing write, so the stimulus may mix writes and events freely, including writes that collide with events on the selected counter.

// File: rtl/perf_bank_pkg.sv
`timescale 1ns/1ps
package perf_bank_pkg;

   // Register offsets inside the 16-entry window
   typedef enum logic [3:0] {
      REG_SEL     = 4'h0,
      REG_CTRL    = 4'h1,
      REG_CFG     = 4'h2,
      REG_CNT_LO  = 4'h3,
      REG_CNT_HI  = 4'h4,
      REG_SNAP_LO = 4'h5,
      REG_SNAP_HI = 4'h6,
      REG_THR_LO  = 4'h7,
      REG_THR_HI  = 4'h8,
      REG_IEN     = 4'h9,
      REG_IACT    = 4'hA,
      REG_BUILD   = 4'hB
   } reg_addr_e;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_SNAP_BIT = 1;
   localparam int SEL_W         = 5;

   function automatic int ctr_width(input int s);
      return 32 + 16 * s;
   endfunction

endpackage

// File: rtl/pcb_counter.sv
`timescale 1ns/1ps
module pcb_counter #(
   parameter int CW       = 48,
   parameter int NUM_COND = 8,
   parameter int COND_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [NUM_COND-1:0] cond,
   input  logic                wr_cfg,
   input  logic                wr_cnt_lo,
   input  logic                wr_cnt_hi,
   input  logic                wr_thr_lo,
   input  logic                wr_thr_hi,
   input  logic [31:0]         wdata,
   output logic [COND_W-1:0]   cfg_q,
   output logic [CW-1:0]       cnt_q,
   output logic [31:0]         cnt_hi_rd,
   output logic [31:0]         thr_lo_rd,
   output logic [31:0]         thr_hi_rd,
   output logic                hit
);
   localparam int CE = 2 ** COND_W;

   logic [CE-1:0] cond_ext;
   logic          inc;
   logic          cnt_load;
   logic          thr_load;
   logic [CW-1:0] cnt_nxt;
   logic [CW-1:0] cnt_wval;
   logic [CW-1:0] thr_wval;
   logic [CW-1:0] thr_q;

   // pad the condition vector so any programmed number indexes safely
   always_comb begin
      cond_ext = '0;
      cond_ext[NUM_COND-1:0] = cond;
   end

   assign inc     = run && (cfg_q != '0) && cond_ext[cfg_q];
   assign cnt_nxt = cnt_q + CW'(1);

   generate
      if (CW > 32) begin : g_wide
         assign cnt_wval  = wr_cnt_hi ? {wdata[CW-33:0], cnt_q[31:0]}
                                      : {cnt_q[CW-1:32], wdata};
         assign thr_wval  = wr_thr_hi ? {wdata[CW-33:0], thr_q[31:0]}
                                      : {thr_q[CW-1:32], wdata};
         assign cnt_load  = wr_cnt_lo | wr_cnt_hi;
         assign thr_load  = wr_thr_lo | wr_thr_hi;
         assign cnt_hi_rd = 32'(cnt_q[CW-1:32]);
         assign thr_hi_rd = 32'(thr_q[CW-1:32]);
      end else begin : g_narrow
         logic unused_hi;
         assign unused_hi = wr_cnt_hi | wr_thr_hi;
         assign cnt_wval  = wdata;
         assign thr_wval  = wdata;
         assign cnt_load  = wr_cnt_lo;
         assign thr_load  = wr_thr_lo;
         assign cnt_hi_rd = '0;
         assign thr_hi_rd = '0;
      end
   endgenerate

   assign thr_lo_rd = thr_q[31:0];

   // a bus write to the count takes the edge; the event is lost
   assign hit = inc && !cnt_load && (cnt_nxt == thr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cnt_q <= '0;
         thr_q <= '0;
      end else begin
         if (wr_cfg)
            cfg_q <= wdata[COND_W-1:0];
         if (cnt_load)
            cnt_q <= cnt_wval;
         else if (inc)
            cnt_q <= cnt_nxt;
         if (thr_load)
            thr_q <= thr_wval;
      end
   end

endmodule

// File: rtl/pcb_irq.sv
`timescale 1ns/1ps
module pcb_irq #(
   parameter int NUM_CTR = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ien,
   input  logic               wr_iact,
   input  logic [31:0]        wdata,
   input  logic [NUM_CTR-1:0] hit,
   output logic [NUM_CTR-1:0] ien_q,
   output logic [NUM_CTR-1:0] iact_q,
   output logic               irq
);
   logic [NUM_CTR-1:0] clr;
   logic               unused_wd;

   assign unused_wd = ^wdata;
   assign clr       = wr_iact ? wdata[NUM_CTR-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         iact_q <= '0;
      end else begin
         if (wr_ien)
            ien_q <= wdata[NUM_CTR-1:0];
         else
            ien_q <= ien_q & ~clr;
         // a fresh hit outranks a clear landing on the same edge
         iact_q <= (iact_q & ~clr) | (hit & ien_q);
      end
   end

   assign irq = |iact_q;

endmodule

// File: rtl/pcb_snapshot.sv
`timescale 1ns/1ps
module pcb_snapshot #(
   parameter int CW = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [CW-1:0] src,
   output logic [CW-1:0] snap_q,
   output logic [31:0]   lo_rd,
   output logic [31:0]   hi_rd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         snap_q <= '0;
      else if (take)
         snap_q <= src;
   end

   assign lo_rd = snap_q[31:0];

   generate
      if (CW > 32) begin : g_wide
         assign hi_rd = 32'(snap_q[CW-1:32]);
      end else begin : g_narrow
         assign hi_rd = '0;
      end
   endgenerate

endmodule

// File: rtl/perf_ctr_bank.sv
`timescale 1ns/1ps
module perf_ctr_bank #(
   parameter int NUM_CTR  = 4,
   parameter int CNT_S    = 1,
   parameter int NUM_COND = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [3:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_COND-1:0] cond_pulse,
   output logic                irq
);
   import perf_bank_pkg::*;

   localparam int CW     = ctr_width(CNT_S);
   localparam int COND_W = $clog2(NUM_COND);

   generate
      if (NUM_CTR < 1 || NUM_CTR > 32) begin : g_bad_count
         $error("NUM_CTR must lie in 1..32");
      end
      if (CNT_S < 0 || CNT_S > 2) begin : g_bad_width
         $error("CNT_S must lie in 0..2");
      end
      if (NUM_COND < 2 || NUM_COND > 255) begin : g_bad_cond
         $error("NUM_COND must lie in 2..255");
      end
   endgenerate

   logic                           en_q;
   logic [SEL_W-1:0]               sel_q;
   logic                           sel_ok;
   logic                           wr_sel, wr_ctrl, wr_cfg, wr_cnt_lo, wr_cnt_hi;
   logic                           wr_thr_lo, wr_thr_hi, wr_ien, wr_iact;
   logic                           snap_take;

   logic [NUM_CTR-1:0][COND_W-1:0] cfg_all;
   logic [NUM_CTR-1:0][CW-1:0]     cnt_all;
   logic [NUM_CTR-1:0]             hit_all;
   logic [31:0]                    cnt_hi_a [NUM_CTR];
   logic [31:0]                    thr_lo_a [NUM_CTR];
   logic [31:0]                    thr_hi_a [NUM_CTR];
   logic [NUM_CTR-1:0]             ien_q;
   logic [NUM_CTR-1:0]             iact_q;
   logic [CW-1:0]                  snap_q;
   logic [31:0]                    snap_lo, snap_hi;

   logic [COND_W-1:0]              cur_cfg;
   logic [CW-1:0]                  cur_cnt;
   logic [31:0]                    cur_cnt_hi, cur_thr_lo, cur_thr_hi;
   logic [31:0]                    build_word;

   // register decode
   assign wr_sel    = bus_wr && (bus_addr == REG_SEL);
   assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
   assign wr_cfg    = bus_wr && (bus_addr == REG_CFG);
   assign wr_cnt_lo = bus_wr && (bus_addr == REG_CNT_LO);
   assign wr_cnt_hi = bus_wr && (bus_addr == REG_CNT_HI);
   assign wr_thr_lo = bus_wr && (bus_addr == REG_THR_LO);
   assign wr_thr_hi = bus_wr && (bus_addr == REG_THR_HI);
   assign wr_ien    = bus_wr && (bus_addr == REG_IEN);
   assign wr_iact   = bus_wr && (bus_addr == REG_IACT);

   assign sel_ok    = int'(sel_q) < NUM_CTR;
   assign snap_take = wr_ctrl && bus_wdata[CTRL_SNAP_BIT] && sel_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else begin
         if (wr_sel)
            sel_q <= bus_wdata[SEL_W-1:0];
         if (wr_ctrl)
            en_q <= bus_wdata[CTRL_RUN_BIT];
      end
   end

   // one counter slice per index
   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
         logic own;
         assign own = sel_ok && (sel_q == SEL_W'(i));

         pcb_counter #(
            .CW       (CW),
            .NUM_COND (NUM_COND),
            .COND_W   (COND_W)
         ) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (en_q),
            .cond      (cond_pulse),
            .wr_cfg    (wr_cfg    && own),
            .wr_cnt_lo (wr_cnt_lo && own),
            .wr_cnt_hi (wr_cnt_hi && own),
            .wr_thr_lo (wr_thr_lo && own),
            .wr_thr_hi (wr_thr_hi && own),
            .wdata     (bus_wdata),
            .cfg_q     (cfg_all[i]),
            .cnt_q     (cnt_all[i]),
            .cnt_hi_rd (cnt_hi_a[i]),
            .thr_lo_rd (thr_lo_a[i]),
            .thr_hi_rd (thr_hi_a[i]),
            .hit       (hit_all[i])
         );
      end
   endgenerate

   pcb_irq #(.NUM_CTR(NUM_CTR)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ien  (wr_ien),
      .wr_iact (wr_iact),
      .wdata   (bus_wdata),
      .hit     (hit_all),
      .ien_q   (ien_q),
      .iact_q  (iact_q),
      .irq     (irq)
   );

   // selected-counter view
   always_comb begin
      cur_cfg    = '0;
      cur_cnt    = '0;
      cur_cnt_hi = '0;
      cur_thr_lo = '0;
      cur_thr_hi = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (sel_ok && (sel_q == SEL_W'(i))) begin
            cur_cfg    = cfg_all[i];
            cur_cnt    = cnt_all[i];
            cur_cnt_hi = cnt_hi_a[i];
            cur_thr_lo = thr_lo_a[i];
            cur_thr_hi = thr_hi_a[i];
         end
      end
   end

   pcb_snapshot #(.CW(CW)) u_snap (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (snap_take),
      .src    (cur_cnt),
      .snap_q (snap_q),
      .lo_rd  (snap_lo),
      .hi_rd  (snap_hi)
   );

   assign build_word = {8'b0, 8'(NUM_COND), 3'b0, 1'b1, 2'b0, 2'(CNT_S),
                        2'b0, 6'(NUM_CTR)};

   always_comb begin
      case (bus_addr)
         REG_SEL:     bus_rdata = 32'(sel_q);
         REG_CTRL:    bus_rdata = 32'(en_q);
         REG_CFG:     bus_rdata = 32'(cur_cfg);
         REG_CNT_LO:  bus_rdata = cur_cnt[31:0];
         REG_CNT_HI:  bus_rdata = cur_cnt_hi;
         REG_SNAP_LO: bus_rdata = snap_lo;
         REG_SNAP_HI: bus_rdata = snap_hi;
         REG_THR_LO:  bus_rdata = cur_thr_lo;
         REG_THR_HI:  bus_rdata = cur_thr_hi;
         REG_IEN:     bus_rdata = 32'(ien_q);
         REG_IACT:    bus_rdata = 32'(iact_q);
         REG_BUILD:   bus_rdata = build_word;
         default:     bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pcb_checker.sv
`timescale 1ns/1ps
module pcb_checker #(
   parameter int NUM_CTR = 4,
   parameter int CW      = 48,
   parameter int COND_W  = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           bus_wr,
   input logic [3:0]                     bus_addr,
   input logic [31:0]                    bus_wdata,
   input logic                           irq,
   input logic                           en_q,
   input logic [4:0]                     sel_q,
   input logic [NUM_CTR-1:0][COND_W-1:0] cfg_all,
   input logic [NUM_CTR-1:0][CW-1:0]     cnt_all,
   input logic [NUM_CTR-1:0]             hit_all,
   input logic [NUM_CTR-1:0]             ien_q,
   input logic [NUM_CTR-1:0]             iact_q,
   input logic [CW-1:0]                  snap_q
);
   import perf_bank_pkg::*;

   logic cnt_wr;
   assign cnt_wr = bus_wr && ((bus_addr == REG_CNT_LO) || (bus_addr == REG_CNT_HI));

   assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (bus_addr == REG_CTRL) && bus_wdata[CTRL_SNAP_BIT]) |=> $stable(snap_q));

   assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cnt_wr) |=> $stable(cnt_all));

   assert_irq_from_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|hit_all));

   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
         assert_never_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_all[i] == '0) && !(cnt_wr && (sel_q == 5'(i))))
            |=> $stable(cnt_all[i]));

         assert_flag_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(iact_q[i]) |-> $past(ien_q[i]));

         assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == REG_IACT) && bus_wdata[i] && !hit_all[i])
            |=> (!iact_q[i] && !ien_q[i]));

         assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == REG_CNT_LO) && (sel_q == 5'(i)))
            |=> (cnt_all[i][31:0] == $past(bus_wdata)));
      end
   endgenerate

endmodule

bind perf_ctr_bank pcb_checker #(
   .NUM_CTR (NUM_CTR),
   .CW      (CW),
   .COND_W  (COND_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .en_q      (en_q),
   .sel_q     (sel_q),
   .cfg_all   (cfg_all),
   .cnt_all   (cnt_all),
   .hit_all   (hit_all),
   .ien_q     (ien_q),
   .iact_q    (iact_q),
   .snap_q    (snap_q)
);

// File: tb/perf_ctr_bank_test.sv
`timescale 1ns/1ps
module perf_ctr_bank_test;
   localparam int N     = 4;
   localparam int S     = 1;
   localparam int NC    = 8;
   localparam int CW    = 32 + 16 * S;
   localparam real TCLK = 8.0;
   localparam logic [63:0] MASK = (CW == 64) ? '1 : ((64'd1 << CW) - 64'd1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] cond_pulse = '0;
   logic          irq;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #(TCLK / 2.0) clk = ~clk;

   perf_ctr_bank #(.NUM_CTR(N), .CNT_S(S), .NUM_COND(NC)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cond_pulse (cond_pulse),
      .irq        (irq)
   );

   // ---------------- behavioural reference ----------------
   logic [63:0] m_cnt [N];
   logic [63:0] m_thr [N];
   int          m_cfg [N];
   logic [63:0] m_snap = '0;
   bit          m_en = 0;
   int          m_sel = 0;
   logic [N-1:0] m_ien = '0;
   logic [N-1:0] m_iact = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_cnt[i] = 0; m_thr[i] = 0; m_cfg[i] = 0;
         end
         m_snap = 0; m_en = 0; m_sel = 0; m_ien = '0; m_iact = '0;
      end else begin
         logic [63:0]  nc [N];
         logic [N-1:0] hits;
         logic [N-1:0] clr;
         bit           ok;
         hits = '0;
         ok = (m_sel < N);
         for (int i = 0; i < N; i++) begin
            bit mine;
            mine = ok && (m_sel == i);
            nc[i] = m_cnt[i];
            if (bus_wr && mine && bus_addr == 4'h3)
               nc[i] = {m_cnt[i][63:32], bus_wdata};
            else if (bus_wr && mine && bus_addr == 4'h4)
               nc[i] = ({32'd0, bus_wdata} << 32 | {32'd0, m_cnt[i][31:0]}) & MASK;
            else if (m_en && m_cfg[i] != 0 && cond_pulse[m_cfg[i]]) begin
               nc[i] = (m_cnt[i] + 1) & MASK;
               if (nc[i] == m_thr[i] && m_ien[i]) hits[i] = 1'b1;
            end
         end
         clr = (bus_wr && bus_addr == 4'hA) ? bus_wdata[N-1:0] : '0;
         if (bus_wr) begin
            case (bus_addr)
               4'h0: m_sel = int'(bus_wdata[4:0]);
               4'h1: begin
                  if (bus_wdata[1] && ok) m_snap = m_cnt[m_sel];
                  m_en = bus_wdata[0];
               end
               4'h2: if (ok) m_cfg[m_sel] = int'(bus_wdata[2:0]);
               4'h7: if (ok) m_thr[m_sel] = {m_thr[m_sel][63:32], bus_wdata};
               4'h8: if (ok) m_thr[m_sel] =
                        ({32'd0, bus_wdata} << 32 | {32'd0, m_thr[m_sel][31:0]}) & MASK;
               4'h9: m_ien = bus_wdata[N-1:0];
               default: ;
            endcase
         end
         if (!(bus_wr && bus_addr == 4'h9)) m_ien = m_ien & ~clr;
         m_iact = (m_iact & ~clr) | hits;
         for (int i = 0; i < N; i++) m_cnt[i] = nc[i];
      end
   end

   function automatic logic [31:0] m_read(input logic [3:0] a);
      bit ok;
      ok = (m_sel < N);
      case (a)
         4'h0: return 32'(m_sel);
         4'h1: return {31'd0, m_en};
         4'h2: return ok ? 32'(m_cfg[m_sel]) : 32'd0;
         4'h3: return ok ? m_cnt[m_sel][31:0] : 32'd0;
         4'h4: return ok ? m_cnt[m_sel][63:32] : 32'd0;
         4'h5: return m_snap[31:0];
         4'h6: return m_snap[63:32];
         4'h7: return ok ? m_thr[m_sel][31:0] : 32'd0;
         4'h8: return ok ? m_thr[m_sel][63:32] : 32'd0;
         4'h9: return 32'(m_ien);
         4'hA: return 32'(m_iact);
         4'hB: return 32'(N) | (32'(S) << 8) | (32'd1 << 12) | (32'(NC) << 16);
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'h0: return "R2";
         4'h1: return "R4";
         4'h2: return "R5";
         4'h3, 4'h4: return "R3";
         4'h5, 4'h6: return "R6";
         4'h7, 4'h8: return "R7";
         4'h9, 4'hA: return "R8";
         4'hB: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // clock-by-clock comparison against the reference
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
         check("R9", 32'(irq), 32'(|m_iact));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; cond_pulse = '0;
   endtask

   task automatic wr_ev(input logic [3:0] a, input logic [31:0] d, input logic [NC-1:0] e);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; cond_pulse = e;
   endtask

   task automatic pulse(input logic [NC-1:0] e, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         bus_wr = 1'b0; cond_pulse = e;
      end
   endtask

   task automatic rd(input logic [3:0] a, input string tag, input logic [31:0] exp);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a; cond_pulse = '0;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(TCLK * 200000);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_cnt[i] = 0; m_thr[i] = 0; m_cfg[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R11 / R12: reset view
      rd(4'hB, "R11", 32'h0008_1104);
      rd(4'h1, "R1", 32'h0);
      rd(4'h3, "R1", 32'h0);
      check("R1", 32'(irq), 32'h0);
      rd(4'hC, "R12", 32'h0);

      // R3 / R5: high word masking, count wrap
      wr(4'h0, 2);
      wr(4'h2, 3);
      wr(4'h4, 32'hABCD_FFFF);
      rd(4'h4, "R3", 32'h0000_FFFF);
      wr(4'h3, 32'hFFFF_FFFF);
      wr(4'h1, 1);
      pulse(8'h08, 1);
      rd(4'h3, "R3", 32'h0);
      rd(4'h4, "R3", 32'h0);
      rd(4'h2, "R5", 32'h3);

      // R5: condition zero never counts (counter 2 counts to 3 meanwhile)
      wr(4'h0, 1);
      pulse(8'hFF, 3);
      rd(4'h3, "R5", 32'h0);

      // R4: run bit off, upper control bits dead
      wr(4'h1, 32'hFFFF_FFFC);
      rd(4'h1, "R4", 32'h0);
      wr(4'h0, 2);
      pulse(8'hFF, 4);
      rd(4'h3, "R4", 32'h3);

      // R6: snapshot capture and hold
      wr(4'h1, 2);
      rd(4'h5, "R6", 32'h3);
      rd(4'h1, "R6", 32'h0);
      wr(4'h3, 77);
      rd(4'h5, "R6", 32'h3);
      rd(4'h6, "R6", 32'h0);

      // R7 / R9 / R8: threshold flag and clearing
      wr(4'h0, 0);
      wr(4'h2, 1);
      wr(4'h7, 3);
      wr(4'h9, 1);
      wr(4'h1, 1);
      pulse(8'h02, 2);
      rd(4'hA, "R7", 32'h0);
      pulse(8'h02, 1);
      rd(4'hA, "R7", 32'h1);
      check("R9", 32'(irq), 32'h1);
      pulse(8'h02, 2);
      rd(4'hA, "R9", 32'h1);
      check("R9", 32'(irq), 32'h1);
      wr(4'hA, 1);
      rd(4'hA, "R8", 32'h0);
      rd(4'h9, "R8", 32'h0);
      check("R9", 32'(irq), 32'h0);

      // R10: write collides with an event
      wr(4'h7, 50);
      wr(4'h9, 1);
      wr_ev(4'h3, 50, 8'h02);
      rd(4'h3, "R10", 32'd50);
      rd(4'hA, "R10", 32'h0);
      pulse(8'h02, 1);
      rd(4'h3, "R10", 32'd51);

      // R8: all-ones clear, and hit beating a clear
      wr(4'h9, 32'hF);
      wr(4'h3, 49);
      pulse(8'h02, 1);
      rd(4'hA, "R8", 32'h1);
      wr(4'hA, 32'hFFFF_FFFF);
      rd(4'hA, "R8", 32'h0);
      rd(4'h9, "R8", 32'h0);
      wr(4'h3, 49);
      wr(4'h9, 1);
      wr_ev(4'hA, 1, 8'h02);
      rd(4'hA, "R8", 32'h1);
      rd(4'h9, "R8", 32'h0);
      wr(4'hA, 32'hFFFF_FFFF);

      // R2: index out of range
      wr(4'h0, 7);
      wr(4'h2, 5);
      rd(4'h2, "R2", 32'h0);
      rd(4'h0, "R2", 32'h7);
      wr(4'h0, 0);
      rd(4'h2, "R2", 32'h1);
      wr(4'h0, 3);
      rd(4'h2, "R2", 32'h0);

      // mixed traffic against the reference
      for (int k = 0; k < 4000; k++) begin
         int r;
         @(negedge clk);
         r = int'($urandom % 8);
         bus_wr    = ($urandom % 3) == 0;
         bus_addr  = 4'($urandom % 16);
         bus_wdata = (r == 0) ? $urandom : (r == 1) ? 32'hFFFF_FFFF : ($urandom % 16);
         cond_pulse = NC'($urandom);
      end
      @(negedge clk);
      bus_wr = 1'b0; cond_pulse = '0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule